// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block is the coherence engine of one private cache on a shared snooping bus. The cache is direct-mapped and write-back, one data word per line. Every line holds a coherence state of Invalid, Shared (readable only) or Modified (this cache owns the only copy and may write it). The processor side serves reads and writes locally when the state allows it. Otherwise it requests the bus and issues a read miss, a write miss or a write-back of a dirty victim, and the processor stalls until that sequence ends.

The bus side watches the transactions of the other caches. It looks each one up in a copy of the tags kept for the snoop path alone. A snooped read miss to a line held Modified makes this cache drive the line's data and drop to Shared, and the flag it raises tells memory to abandon its own reply. A snooped write miss removes the local copy, and a dirty copy is flushed first. If a snoop and a processor access arrive in the same cycle, the snoop is handled first and the processor access starts one cycle later.

Top module: `msi_cache_ctrl`

## Requirements
- R1: Out of reset every line is Invalid and `cpu_done`, `bus_req` and `snp_flush` are low. The address splits into the index (its low IDX_W bits) and the tag (the remaining upper bits).
- R2: A read to a line that is Invalid or holds another tag issues bus command 1 (read miss) with the requested address. The line is then filled with `bus_rdata` in Shared state, and that value is returned on `cpu_rdata`.
- R3: A write to an Invalid or Shared line, or to a line holding another tag, issues bus command 2 (write miss) with the requested address. The line then holds the write data in Modified state.
- R4: A read with a matching tag on a Shared or Modified line, and a write with a matching tag on a Modified line, raise no `bus_req`. `cpu_done` is high in the cycle after the cycle in which the request is taken, and a read returns the stored word.
- R5: If the line to be replaced is Modified with another tag, bus command 3 (write-back) comes first. It carries the victim address (old tag above index) and the victim data, and the miss command follows only after the write-back is acknowledged.
- R6: A snooped read miss (`snp_cmd` 1) whose tag matches a Modified line pulses `snp_flush` for one cycle, in the cycle after `snp_valid`, with the line data on `snp_data`, and the line becomes Shared. Any other snoop (a Shared, Invalid or other-tag line, or `snp_cmd` 0 or 3) raises no flush. A read miss to a Shared line, and any snoop with `snp_cmd` 0 or 3, leave the line state unchanged.
- R7: A snooped write miss (`snp_cmd` 2) whose tag matches invalidates the line. If the line was Modified, `snp_flush` first pulses with its data.
- R8: `bus_req` rises before any command is driven. Once the grant is seen, `bus_req` stays high until the acknowledge of the last command of the sequence, so the bus is not released between a write-back and its miss. A command is held until its acknowledge.
- R9: While `snp_valid` is high the processor request is not taken. The snoop updates the line first, and the waiting request then acts on the updated state.
- R10: The processor stalls until its whole sequence ends. `cpu_done` pulses for exactly one cycle per request, in the cycle after the final acknowledge, and `bus_req` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the current command |
| bus_wdata | output | DATA_W | Write-back data (write data on a write miss) |
| bus_ack | input | 1 | Completion of the current command |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_ack` on a read miss |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the block; memory abandons its reply |
| snp_data | output | DATA_W | Supplied block data, valid with `snp_flush` |

## Verification
A hit gives `cpu_done` and its data exactly one cycle after the request is taken, or two cycles when a snoop arrives in the same cycle. On a miss, `bus_req` appears one cycle after the request. A command appears one cycle after the grant, a write-back is replaced by its miss one cycle after its acknowledge, and `cpu_done` follows the final acknowledge by one cycle. A snoop's flush appears one cycle after `snp_valid`. The bench drives every input on the falling edge and reads outputs on the falling edge, counting falling edges from the request, so each result is read in the exact cycle it is due. A bus model answers commands and a reference model of line states and memory gives the expected command order, addresses and data. The model is driven through directed sequences and a pseudo-random sweep over all addresses of a four-line setup.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_NONE   = 2'd0,
        BUS_RDMISS = 2'd1,
        BUS_WRMISS = 2'd2,
        BUS_WB     = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CP_IDLE,
        CP_ARB,
        CP_WB,
        CP_MISS,
        CP_DONE
    } cpu_fsm_e;

    typedef struct packed {
        line_st_e nxt;
        logic     flush;
    } snoop_act_t;

    // Reaction of a line that matched a snooped transaction.
    function automatic snoop_act_t snoop_action(line_st_e cur, bus_cmd_e cmd);
        snoop_act_t a;
        a.nxt   = cur;
        a.flush = 1'b0;
        case (cmd)
            BUS_RDMISS: begin
                if (cur == LN_MOD) begin
                    a.nxt   = LN_SHR;
                    a.flush = 1'b1;
                end
            end
            BUS_WRMISS: begin
                a.flush = (cur == LN_MOD);
                a.nxt   = LN_INV;
            end
            default: ;
        endcase
        return a;
    endfunction

    // State a line takes when its miss completes.
    function automatic line_st_e fill_state(logic is_write);
        return is_write ? LN_MOD : LN_SHR;
    endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    // processor-side lookup
    input  logic [IDX_W-1:0]  cpu_idx,
    output line_st_e          cpu_st,
    output logic [TAG_W-1:0]  cpu_tag,
    output logic [DATA_W-1:0] cpu_data,
    // snoop-side lookup (separate tag copy)
    input  logic [IDX_W-1:0]  snp_idx,
    output line_st_e          snp_st,
    output logic [TAG_W-1:0]  snp_tag,
    output logic [DATA_W-1:0] snp_data,
    // processor-side update
    input  logic              cwr_en,
    input  line_st_e          cwr_st,
    input  logic [TAG_W-1:0]  cwr_tag,
    input  logic [DATA_W-1:0] cwr_data,
    // snoop-side state update
    input  logic              swr_en,
    input  logic [IDX_W-1:0]  swr_idx,
    input  line_st_e          swr_st
);

    localparam int LINES = 1 << IDX_W;

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [TAG_W-1:0]  stag_q [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic same_line;
    assign same_line = swr_en && (swr_idx == cpu_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LN_INV;
                tag_q[i]  <= '0;
                stag_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            if (cwr_en) begin
                tag_q[cpu_idx]  <= cwr_tag;
                stag_q[cpu_idx] <= cwr_tag;
                data_q[cpu_idx] <= cwr_data;
                if (!same_line) begin
                    st_q[cpu_idx] <= cwr_st;
                end
            end
            // snoop update wins on the same line
            if (swr_en) begin
                st_q[swr_idx] <= swr_st;
            end
        end
    end

    assign cpu_st   = st_q[cpu_idx];
    assign cpu_tag  = tag_q[cpu_idx];
    assign cpu_data = data_q[cpu_idx];
    assign snp_st   = st_q[snp_idx];
    assign snp_tag  = stag_q[snp_idx];
    assign snp_data = data_q[snp_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [TAG_W-1:0]  req_tag,
    input  line_st_e          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              swr_en,
    output line_st_e          swr_st,
    output logic              flush,
    output logic [DATA_W-1:0] flush_data
);

    logic       hit;
    snoop_act_t act;

    assign hit    = snp_valid && (line_st != LN_INV) && (line_tag == req_tag);
    assign act    = snoop_action(line_st, snp_cmd);
    assign swr_en = hit && (act.nxt != line_st);
    assign swr_st = act.nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush      <= 1'b0;
            flush_data <= '0;
        end else begin
            flush <= hit && act.flush;
            if (hit && act.flush) begin
                flush_data <= line_data;
            end
        end
    end

endmodule

// File: rtl/msi_cpu_ctrl.sv
module msi_cpu_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  logic                    snp_busy,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output bus_cmd_e                bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_ack,
    input  logic [DATA_W-1:0]       bus_rdata,
    input  line_st_e                line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]       line_data,
    output logic                    cwr_en,
    output line_st_e                cwr_st,
    output logic [ADDR_W-IDX_W-1:0] cwr_tag,
    output logic [DATA_W-1:0]       cwr_data
);

    localparam int TAG_W = ADDR_W - IDX_W;

    cpu_fsm_e          st_q, st_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic              tag_match, hit;

    assign req_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx   = cpu_addr[IDX_W-1:0];
    assign tag_match = (line_tag == req_tag);
    assign hit       = (line_st != LN_INV) && tag_match;

    always_comb begin
        st_d     = st_q;
        rdata_d  = rdata_q;
        cwr_en   = 1'b0;
        cwr_st   = line_st;
        cwr_tag  = req_tag;
        cwr_data = line_data;
        case (st_q)
            CP_IDLE: begin
                if (cpu_req && !snp_busy) begin
                    if (hit && !cpu_we) begin
                        rdata_d = line_data;
                        st_d    = CP_DONE;
                    end else if (hit && cpu_we && line_st == LN_MOD) begin
                        cwr_en   = 1'b1;
                        cwr_st   = LN_MOD;
                        cwr_data = cpu_wdata;
                        rdata_d  = cpu_wdata;
                        st_d     = CP_DONE;
                    end else begin
                        st_d = CP_ARB;
                    end
                end
            end
            CP_ARB: begin
                if (bus_gnt) begin
                    st_d = (line_st == LN_MOD && !tag_match) ? CP_WB : CP_MISS;
                end
            end
            CP_WB: begin
                if (bus_ack) begin
                    st_d = CP_MISS;
                end
            end
            CP_MISS: begin
                if (bus_ack) begin
                    cwr_en   = 1'b1;
                    cwr_st   = fill_state(cpu_we);
                    cwr_data = cpu_we ? cpu_wdata : bus_rdata;
                    rdata_d  = cpu_we ? cpu_wdata : bus_rdata;
                    st_d     = CP_DONE;
                end
            end
            CP_DONE: st_d = CP_IDLE;
            default: st_d = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CP_IDLE;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
        end
    end

    always_comb begin
        bus_cmd   = BUS_NONE;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        if (st_q == CP_WB) begin
            bus_cmd   = BUS_WB;
            bus_addr  = {line_tag, req_idx};
            bus_wdata = line_data;
        end else if (st_q == CP_MISS) begin
            bus_cmd = cpu_we ? BUS_WRMISS : BUS_RDMISS;
        end
    end

    assign bus_req   = (st_q == CP_ARB) || (st_q == CP_WB) || (st_q == CP_MISS);
    assign cpu_done  = (st_q == CP_DONE);
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);

    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e          c_st, s_st, cwr_st, swr_st;
    logic [TAG_W-1:0]  c_tag, s_tag, cwr_tag;
    logic [DATA_W-1:0] c_data, s_data, cwr_data;
    logic              cwr_en, swr_en;
    bus_cmd_e          cmd_e;

    msi_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .cpu_idx (cpu_addr[IDX_W-1:0]),
        .cpu_st  (c_st),
        .cpu_tag (c_tag),
        .cpu_data(c_data),
        .snp_idx (snp_addr[IDX_W-1:0]),
        .snp_st  (s_st),
        .snp_tag (s_tag),
        .snp_data(s_data),
        .cwr_en  (cwr_en),
        .cwr_st  (cwr_st),
        .cwr_tag (cwr_tag),
        .cwr_data(cwr_data),
        .swr_en  (swr_en),
        .swr_idx (snp_addr[IDX_W-1:0]),
        .swr_st  (swr_st)
    );

    msi_snoop_unit #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_snoop (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .req_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .line_st   (s_st),
        .line_tag  (s_tag),
        .line_data (s_data),
        .swr_en    (swr_en),
        .swr_st    (swr_st),
        .flush     (snp_flush),
        .flush_data(snp_data)
    );

    msi_cpu_ctrl #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_cpu (
        .clk      (clk),
        .rst      (rst),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_done (cpu_done),
        .cpu_rdata(cpu_rdata),
        .snp_busy (snp_valid),
        .bus_req  (bus_req),
        .bus_gnt  (bus_gnt),
        .bus_cmd  (cmd_e),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_ack  (bus_ack),
        .bus_rdata(bus_rdata),
        .line_st  (c_st),
        .line_tag (c_tag),
        .line_data(c_data),
        .cwr_en   (cwr_en),
        .cwr_st   (cwr_st),
        .cwr_tag  (cwr_tag),
        .cwr_data (cwr_data)
    );

    assign bus_cmd = cmd_e;

endmodule

// File: rtl/msi_cache_ctrl_chk.sv
module msi_cache_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_done,
    input logic       bus_req,
    input logic [1:0] bus_cmd,
    input logic       bus_ack,
    input logic       snp_valid,
    input logic       snp_flush
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!bus_req && !cpu_done && !snp_flush));

    // R8
    cmd_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != 2'd0) |-> bus_req);

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> bus_req);

    // R8
    cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != 2'd0 && !bus_ack) |=> $stable(bus_cmd));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    // R10
    done_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !bus_req);

    // R6
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> $past(snp_valid));

endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_done (cpu_done),
    .bus_req  (bus_req),
    .bus_cmd  (bus_cmd),
    .bus_ack  (bus_ack),
    .snp_valid(snp_valid),
    .snp_flush(snp_flush)
);

// File: tb/sim_msi_cache_ctrl.sv
module sim_msi_cache_ctrl;

    localparam int CLK_PER = 10;
    localparam int AW = 4;
    localparam int IW = 2;
    localparam int DW = 8;
    localparam int NL = 1 << IW;
    localparam int NA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_flush;
    logic [DW-1:0] snp_data;

    int checks = 0;
    int fails  = 0;
    int m_st   [NL];
    int m_tag  [NL];
    int m_data [NL];
    int mem    [NA];
    logic [15:0] lf = 16'hACE1;

    always #(CLK_PER/2) clk = ~clk;

    msi_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_flush(snp_flush), .snp_data(snp_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // line states in the model: 0 Invalid, 1 Shared, 2 Modified
    task automatic model_snoop(input int scmd, input int idx, input int tag);
        if (m_st[idx] != 0 && m_tag[idx] == tag) begin
            if (scmd == 1 && m_st[idx] == 2) m_st[idx] = 1;
            if (scmd == 2) m_st[idx] = 0;
        end
    endtask

    task automatic snoop_op(input int scmd, input int addr);
        int idx = addr % NL;
        int tag = addr / NL;
        int exp_fl = (m_st[idx] == 2 && m_tag[idx] == tag && (scmd == 1 || scmd == 2)) ? 1 : 0;
        int exp_fd = m_data[idx];
        string rq = (scmd == 2) ? "R7" : "R6";
        snp_valid = 1'b1;
        snp_cmd   = scmd[1:0];
        snp_addr  = addr[AW-1:0];
        model_snoop(scmd, idx, tag);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(rq, "snoop flush", int'(snp_flush), exp_fl);
        if (exp_fl == 1) chk(rq, "snoop data", int'(snp_data), exp_fd);
        @(negedge clk);
        chk("R6", "flush lasts one cycle", int'(snp_flush), 0);
    endtask

    task automatic cpu_op(input bit we, input int addr, input int wd, input int scmd, input bit with_snp);
        int idx = addr % NL;
        int tag = addr / NL;
        int cyc = 0;
        int miss_cmd = 0;
        int rd = 0;
        int exp_fl = 0;
        int exp_fd = 0;
        bit got_done = 0, saw_req = 0, saw_wb = 0, broke = 0;
        bit loc, exp_wb;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr[AW-1:0];
        cpu_wdata = wd[DW-1:0];
        if (with_snp) begin
            snp_valid = 1'b1;
            snp_cmd   = scmd[1:0];
            snp_addr  = addr[AW-1:0];
            exp_fl = (m_st[idx] == 2 && m_tag[idx] == tag && (scmd == 1 || scmd == 2)) ? 1 : 0;
            exp_fd = m_data[idx];
            model_snoop(scmd, idx, tag);
        end
        loc = (m_st[idx] != 0 && m_tag[idx] == tag && !we) ||
              (m_st[idx] == 2 && m_tag[idx] == tag && we);
        exp_wb = !loc && m_st[idx] == 2 && m_tag[idx] != tag;
        while (cyc < 60 && !got_done) begin
            @(negedge clk);
            cyc++;
            bus_ack = 1'b0;
            if (with_snp && cyc == 1) begin
                snp_valid = 1'b0;
                chk("R9", "flush on same-cycle snoop", int'(snp_flush), exp_fl);
                if (exp_fl == 1) chk("R9", "same-cycle snoop data", int'(snp_data), exp_fd);
            end
            if (bus_req) saw_req = 1;
            if (cpu_done) begin
                got_done = 1;
                rd = int'(cpu_rdata);
            end else begin
                if (bus_gnt && !bus_req) broke = 1;
                if (bus_cmd != 2'd0 && bus_gnt) begin
                    if (bus_cmd == 2'd3) begin
                        chk("R5", "write-back address", int'(bus_addr), m_tag[idx] * NL + idx);
                        chk("R5", "write-back data", int'(bus_wdata), m_data[idx]);
                        chk("R5", "write-back before miss", miss_cmd, 0);
                        mem[int'(bus_addr)] = int'(bus_wdata);
                        saw_wb = 1;
                    end else begin
                        miss_cmd = int'(bus_cmd);
                        chk(we ? "R3" : "R2", "miss address", int'(bus_addr), addr);
                        bus_rdata = mem[addr][DW-1:0];
                    end
                    bus_ack = 1'b1;
                end
                if (bus_req && !bus_gnt) bus_gnt = 1'b1;
            end
        end
        cpu_req = 1'b0;
        bus_gnt = 1'b0;
        bus_ack = 1'b0;
        chk("R10", "completion seen", int'(got_done), 1);
        if (loc) begin
            chk("R4", "hit latency", cyc, with_snp ? 2 : 1);
            chk("R4", "hit raised bus request", int'(saw_req), 0);
            if (!we) chk("R4", "hit read data", rd, m_data[idx]);
            else m_data[idx] = wd % 256;
        end else begin
            chk("R5", "write-back issued", int'(saw_wb), int'(exp_wb));
            chk(we ? "R3" : "R2", "miss command", miss_cmd, we ? 2 : 1);
            chk("R8", "bus dropped mid-sequence", int'(broke), 0);
            if (!we) chk("R2", "fill data returned", rd, mem[addr]);
            m_st[idx]   = we ? 2 : 1;
            m_tag[idx]  = tag;
            m_data[idx] = we ? (wd % 256) : mem[addr];
        end
        @(negedge clk);
        chk("R10", "single completion pulse", int'(cpu_done), 0);
    endtask

    initial begin
        #(CLK_PER * 150000);
        fails++;
        $display("FAIL R10 watchdog expired: actual 0 expected 1 completed run");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NA; i++) mem[i] = (i * 37 + 11) % 256;
        for (int i = 0; i < NL; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "done after reset", int'(cpu_done), 0);
        chk("R1", "bus request after reset", int'(bus_req), 0);
        chk("R1", "flush after reset", int'(snp_flush), 0);
        chk("R1", "bus command after reset", int'(bus_cmd), 0);
        @(negedge clk);

        // R1 R2: every line starts Invalid, reads fill it Shared
        for (int i = 0; i < NL; i++) cpu_op(1'b0, i, 0, 0, 1'b0);
        cpu_op(1'b0, 1, 0, 0, 1'b0);            // R4 read hit on Shared
        cpu_op(1'b1, 1, 8'h5A, 0, 1'b0);        // R3 upgrade from Shared
        cpu_op(1'b1, 1, 8'hC3, 0, 1'b0);        // R4 write hit on Modified
        cpu_op(1'b0, 1, 0, 0, 1'b0);            // R4 read hit on Modified
        cpu_op(1'b0, 1 + NL, 0, 0, 1'b0);       // R5 dirty victim
        snoop_op(2, 2);                         // R7 Shared invalidated
        cpu_op(1'b1, 2, 8'h21, 0, 1'b0);        // R3 write to Invalid
        snoop_op(1, 2);                         // R6 dirty supply, to Shared
        cpu_op(1'b1, 2, 8'h44, 0, 1'b0);        // R6 line now Shared
        snoop_op(2, 2);                         // R7 dirty flush and invalidate
        cpu_op(1'b0, 2, 0, 0, 1'b0);
        cpu_op(1'b1, 3, 8'h77, 0, 1'b0);
        snoop_op(1, 3 + NL);                    // R6 other tag ignored
        snoop_op(3, 3);                         // R6 command 3 ignored
        snoop_op(0, 3);                         // R6 command 0 ignored
        cpu_op(1'b1, 3, 8'h78, 0, 1'b0);        // R6 still Modified
        cpu_op(1'b1, 3, 8'h90, 2, 1'b1);        // R9 snoop wins, write miss follows
        cpu_op(1'b0, 3, 0, 1, 1'b1);            // R9 flush then read hit
        snoop_op(1, 3);                         // R6 read miss to Shared: no action
        cpu_op(1'b0, 3, 0, 0, 1'b0);

        for (int n = 0; n < 700; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[1:0])
                2'd0: cpu_op(1'b0, int'(lf[5:2]), 0, 0, 1'b0);
                2'd1: cpu_op(1'b1, int'(lf[5:2]), int'(lf[13:6]), 0, 1'b0);
                2'd2: snoop_op(int'(lf[15:14]), int'(lf[5:2]));
                default: cpu_op(lf[6], int'(lf[5:2]), int'(lf[13:6]), int'(lf[15:14]), 1'b1);
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule